// File: doc/BRIEF.md
# Register-Driven Bus-Master Word Mover

This block moves a software-chosen number of 32-bit words between a small on-chip word store and a target on a local bus, acting as the bus master. Software gives the target address, the word count and the direction, then raises a start level. The engine asks for the bus and waits for a grant. It then runs one single-word cycle after another, each closed by a ready/acknowledge from the target. At the end it emits a one-cycle completion pulse, which an interrupt controller uses as its source bit 0.

The start control is a level, not an edge. Once a transfer has finished, the engine stays in its completion state for as long as start is high. It returns to idle only after software clears start, so one raised level yields exactly one transfer. The engine state is a registered 2-bit field that software can read at any time. Software also reaches the word store through its own port: it loads words before a write transfer and reads them back after a read transfer.

Top module: `burst_xfer_engine`

## Requirements
- R1: After reset, `eng_state` is 0 (idle), and `bus_req`, `bus_cyc` and `xfer_done` are all low.
- R2: With `ctl_write`=1, word i of the store (i from 0) is driven on `bus_wdata` with `bus_we`=1 at address `cfg_addr`+4·i. Words go out in increasing i.
- R3: With `ctl_write`=0, the `bus_rdata` value acknowledged for the cycle at `cfg_addr`+4·i is written into store word i.
- R4: A count of 0 produces the completion pulse with no bus request and no bus cycle.
- R5: A count above the store depth (16) is clamped, so exactly 16 word cycles run.
- R6: While `bus_cyc` is high and `bus_ack` is low, the cycle and its address are held. Waiting any number of cycles for the acknowledge loses no word.
- R7: `xfer_done` is high for exactly one cycle per transfer. While start stays high after completion, the engine stays in state 3 and starts nothing new. Start must go low and then high again to begin another transfer.
- R8: `eng_state` reads 0 = idle, 1 = waiting for grant, 2 = moving words, 3 = completed.
- R9: `bus_req` is held high until `bus_gnt` arrives, and no `bus_cyc` is issued before the grant.
- R10: A read transfer of n words leaves store words n..15 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_start | input | 1 | Start level from the control register |
| ctl_write | input | 1 | Direction: 1 = store to bus, 0 = bus to store |
| cfg_addr | input | 32 | First local-bus address of the transfer |
| cfg_count | input | 8 | Number of words to move |
| eng_state | output | 2 | Readable engine state |
| xfer_done | output | 1 | One-cycle completion pulse |
| sw_we | input | 1 | Software write strobe into the store |
| sw_addr | input | 4 | Software store index |
| sw_wdata | input | 32 | Software write data |
| sw_rdata | output | 32 | Store word at `sw_addr`, one cycle later |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| bus_cyc | output | 1 | Word cycle active |
| bus_we | output | 1 | Cycle is a write |
| bus_addr | output | 32 | Cycle address |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid with `bus_ack` |
| bus_ack | input | 1 | Target ready/acknowledge |

## Verification
The hardest case to reach from the ports is a completed transfer with start still held high. A design that wrongly re-arms on a level would start a second transfer on its own. To reach it, the bench holds start high for many cycles after the completion pulse and watches for any new request or cycle. It then lowers start, raises it again, and expects a second transfer. The bus target model takes a programmable grant delay and wait-state count, so address hold and word ordering are exercised under stalls.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_XFER = 2'd2,
    ST_DONE = 2'd3
  } xfer_state_e;
endpackage

// File: rtl/xfer_umem.sv
module xfer_umem #(
  parameter int DEPTH = 16,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          eng_we,
  input  logic [AW-1:0] eng_addr,
  input  logic [DW-1:0] eng_wdata,
  output logic [DW-1:0] eng_q,
  input  logic          sw_we,
  input  logic [AW-1:0] sw_addr,
  input  logic [DW-1:0] sw_wdata,
  output logic [DW-1:0] sw_q
);
  logic [DW-1:0] mem [DEPTH];

  // single write port: the engine has priority over software
  always_ff @(posedge clk) begin
    if (eng_we)
      mem[eng_addr] <= eng_wdata;
    else if (sw_we)
      mem[sw_addr] <= sw_wdata;
  end

  always_ff @(posedge clk) begin
    eng_q <= mem[eng_addr];
    sw_q  <= mem[sw_addr];
  end
endmodule

// File: rtl/xfer_seq.sv
module xfer_seq
  import xfer_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 32,
  localparam int AW    = $clog2(DEPTH),
  localparam int RW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              write_dir,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [CNT_W-1:0]  cfg_count,
  input  logic              gnt,
  input  logic              ack,
  output xfer_state_e       state,
  output logic              req,
  output logic              cyc,
  output logic              dir,
  output logic [ADDR_W-1:0] addr,
  output logic [AW-1:0]     idx,
  output logic              mem_we,
  output logic              done_pulse
);
  logic [RW-1:0] rem;
  logic [RW-1:0] eff_count;

  always_comb begin
    if (cfg_count > CNT_W'(DEPTH))
      eff_count = RW'(DEPTH);
    else
      eff_count = RW'(cfg_count);
  end

  assign mem_we = (state == ST_XFER) && cyc && ack && !dir;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      req        <= 1'b0;
      cyc        <= 1'b0;
      dir        <= 1'b0;
      addr       <= '0;
      idx        <= '0;
      rem        <= '0;
      done_pulse <= 1'b0;
    end else begin
      done_pulse <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            addr <= cfg_addr;
            dir  <= write_dir;
            idx  <= '0;
            rem  <= eff_count;
            if (eff_count == '0) begin
              state      <= ST_DONE;
              done_pulse <= 1'b1;
            end else begin
              state <= ST_REQ;
              req   <= 1'b1;
            end
          end
        end
        ST_REQ: begin
          if (gnt) state <= ST_XFER;
        end
        ST_XFER: begin
          if (!cyc) begin
            cyc <= 1'b1;
          end else if (ack) begin
            cyc  <= 1'b0;
            idx  <= idx + 1'b1;
            addr <= addr + ADDR_W'(4);
            rem  <= rem - 1'b1;
            if (rem == RW'(1)) begin
              state      <= ST_DONE;
              req        <= 1'b0;
              done_pulse <= 1'b1;
            end
          end
        end
        ST_DONE: begin
          if (!start) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cyc && !ack) |=> (cyc && $stable(addr))); // R6
  AST_CYC_UNDER_REQ: assert property (@(posedge clk) disable iff (rst)
    cyc |-> req); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done_pulse |=> !done_pulse); // R7
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DONE && start) |=> (state == ST_DONE)); // R7
  AST_REM_BOUND: assert property (@(posedge clk) disable iff (rst)
    rem <= RW'(DEPTH)); // R5
endmodule

// File: rtl/burst_xfer_engine.sv
module burst_xfer_engine
  import xfer_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DW     = 32,
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 32,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_start,
  input  logic              ctl_write,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [CNT_W-1:0]  cfg_count,
  output logic [1:0]        eng_state,
  output logic              xfer_done,
  input  logic              sw_we,
  input  logic [AW-1:0]     sw_addr,
  input  logic [DW-1:0]     sw_wdata,
  output logic [DW-1:0]     sw_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              bus_cyc,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DW-1:0]     bus_wdata,
  input  logic [DW-1:0]     bus_rdata,
  input  logic              bus_ack
);
  xfer_state_e   st;
  logic          dir;
  logic [AW-1:0] idx;
  logic          mem_we;

  xfer_seq #(
    .DEPTH (DEPTH),
    .CNT_W (CNT_W),
    .ADDR_W(ADDR_W)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (ctl_start),
    .write_dir (ctl_write),
    .cfg_addr  (cfg_addr),
    .cfg_count (cfg_count),
    .gnt       (bus_gnt),
    .ack       (bus_ack),
    .state     (st),
    .req       (bus_req),
    .cyc       (bus_cyc),
    .dir       (dir),
    .addr      (bus_addr),
    .idx       (idx),
    .mem_we    (mem_we),
    .done_pulse(xfer_done)
  );

  xfer_umem #(
    .DEPTH(DEPTH),
    .DW   (DW)
  ) u_mem (
    .clk      (clk),
    .eng_we   (mem_we),
    .eng_addr (idx),
    .eng_wdata(bus_rdata),
    .eng_q    (bus_wdata),
    .sw_we    (sw_we),
    .sw_addr  (sw_addr),
    .sw_wdata (sw_wdata),
    .sw_q     (sw_rdata)
  );

  assign eng_state = st;
  assign bus_we    = dir;

  AST_STATE_RESET: assert property (@(posedge clk)
    rst |=> (eng_state == 2'd0 && !bus_req && !xfer_done)); // R1
  AST_DONE_IN_STATE: assert property (@(posedge clk) disable iff (rst)
    xfer_done |-> (eng_state == 2'd3)); // R8
endmodule

// File: tb/burst_xfer_engine_bench.sv
module burst_xfer_engine_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctl_start = 1'b0;
  logic        ctl_write = 1'b0;
  logic [31:0] cfg_addr = '0;
  logic [7:0]  cfg_count = '0;
  logic [1:0]  eng_state;
  logic        xfer_done;
  logic        sw_we = 1'b0;
  logic [3:0]  sw_addr = '0;
  logic [31:0] sw_wdata = '0;
  logic [31:0] sw_rdata;
  logic        bus_req, bus_cyc, bus_we;
  logic        bus_gnt = 1'b0;
  logic [31:0] bus_addr, bus_wdata;
  logic [31:0] bus_rdata = '0;
  logic        bus_ack = 1'b0;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  int gnt_delay = 0;
  int wait_st = 0;
  int gnt_cnt = 0;
  int wcnt = 0;
  int acks = 0;
  int req_seen = 0;
  int done_cnt = 0;
  int order_err = 0;
  logic [31:0] base = '0;
  logic [31:0] tgt [64];

  always #2 clk = ~clk;

  burst_xfer_engine u_burst_xfer_engine (
    .clk(clk), .rst(rst), .ctl_start(ctl_start), .ctl_write(ctl_write),
    .cfg_addr(cfg_addr), .cfg_count(cfg_count), .eng_state(eng_state),
    .xfer_done(xfer_done), .sw_we(sw_we), .sw_addr(sw_addr),
    .sw_wdata(sw_wdata), .sw_rdata(sw_rdata), .bus_req(bus_req),
    .bus_gnt(bus_gnt), .bus_cyc(bus_cyc), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ack(bus_ack)
  );

  // bus target model, updated away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (xfer_done) done_cnt++;
    if (bus_req) req_seen++;
    if (bus_req && !bus_gnt) begin
      if (gnt_cnt >= gnt_delay) bus_gnt = 1'b1;
      else gnt_cnt++;
    end else if (!bus_req) begin
      bus_gnt = 1'b0;
      gnt_cnt = 0;
    end
    if (bus_cyc && !bus_ack) begin
      if (wcnt >= wait_st) begin
        if (bus_addr != base + 32'(acks * 4)) order_err++;
        if (bus_we) tgt[bus_addr[7:2]] = bus_wdata;
        else bus_rdata = tgt[bus_addr[7:2]];
        bus_ack = 1'b1;
        acks++;
        wcnt = 0;
      end else wcnt++;
    end else bus_ack = 1'b0;
  end

  initial begin : watchdog
    wait (cycles > 150000);
    fails++;
    $display("FAIL watchdog: actual %0d cycles, expected < 150000", cycles);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic sw_wr(input int i, input logic [31:0] d);
    @(negedge clk);
    sw_we = 1'b1; sw_addr = 4'(i); sw_wdata = d;
    @(negedge clk);
    sw_we = 1'b0;
  endtask

  task automatic sw_rd(input int i, output logic [31:0] d);
    @(negedge clk);
    sw_addr = 4'(i);
    @(negedge clk);
    d = sw_rdata;
  endtask

  task automatic run(input bit wr, input logic [31:0] a, input int n);
    @(negedge clk);
    ctl_write = wr; cfg_addr = a; cfg_count = 8'(n); base = a;
    acks = 0; order_err = 0; req_seen = 0; done_cnt = 0;
    ctl_start = 1'b1;
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      if (done_cnt != 0) break;
    end
  endtask

  task automatic release_start();
    @(negedge clk);
    ctl_start = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(eng_state == 2'd0, "R1 state", 32'(eng_state), 0);
    chk(!bus_req && !bus_cyc && !xfer_done, "R1 outputs", {bus_req, bus_cyc, xfer_done}, 0);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_write(input int n, input int ws);
    wait_st = ws; gnt_delay = 0;
    for (int i = 0; i < 16; i++) sw_wr(i, 32'hA500_0000 + 32'(i * 7 + n));
    for (int i = 0; i < 64; i++) tgt[i] = 32'hDEAD_0000 + 32'(i);
    run(1'b1, 32'h40, n);
    chk(acks == n, "R2 word count", 32'(acks), 32'(n));
    chk(order_err == 0, "R2 address order", 32'(order_err), 0);
    for (int i = 0; i < n; i++)
      chk(tgt[16 + i] == 32'hA500_0000 + 32'(i * 7 + n), "R2 data", tgt[16 + i], 32'hA500_0000 + 32'(i * 7 + n));
    chk(tgt[16 + n] == 32'hDEAD_0000 + 32'(16 + n), "R2 no extra word", tgt[16 + n], 32'hDEAD_0000 + 32'(16 + n));
    release_start();
  endtask

  task automatic t_read(input int n, input int ws);
    logic [31:0] d;
    wait_st = ws; gnt_delay = 0;
    for (int i = 0; i < 16; i++) sw_wr(i, 32'h5A5A_0000 + 32'(i));
    for (int i = 0; i < 64; i++) tgt[i] = 32'hC000_0000 + 32'(i * 3);
    run(1'b0, 32'h80, n);
    chk(acks == n, "R3 word count", 32'(acks), 32'(n));
    chk(order_err == 0, "R6 address order under waits", 32'(order_err), 0);
    release_start();
    for (int i = 0; i < 16; i++) begin
      sw_rd(i, d);
      if (i < n) chk(d == 32'hC000_0000 + 32'((32 + i) * 3), "R3 stored word", d, 32'hC000_0000 + 32'((32 + i) * 3));
      else chk(d == 32'h5A5A_0000 + 32'(i), "R10 untouched word", d, 32'h5A5A_0000 + 32'(i));
    end
  endtask

  task automatic t_zero();
    run(1'b1, 32'h0, 0);
    chk(done_cnt == 1, "R4 done pulse", 32'(done_cnt), 1);
    chk(acks == 0 && req_seen == 0, "R4 no bus activity", 32'(acks + req_seen), 0);
    release_start();
  endtask

  task automatic t_clamp();
    wait_st = 1; gnt_delay = 0;
    run(1'b0, 32'h0, 40);
    chk(acks == 16, "R5 clamped count", 32'(acks), 16);
    release_start();
  endtask

  task automatic t_hold();
    wait_st = 0; gnt_delay = 0;
    run(1'b1, 32'h0, 2);
    chk(eng_state == 2'd3, "R8 completed state", 32'(eng_state), 3);
    repeat (20) @(negedge clk);
    chk(done_cnt == 1, "R7 single pulse", 32'(done_cnt), 1);
    chk(acks == 2 && eng_state == 2'd3 && !bus_req, "R7 start ignored while high", 32'(acks), 2);
    release_start();
    chk(eng_state == 2'd0, "R8 idle after start low", 32'(eng_state), 0);
    run(1'b1, 32'h0, 3);
    chk(acks == 3 && done_cnt == 1, "R7 restart after low", 32'(acks), 3);
    release_start();
  endtask

  task automatic t_late_grant();
    wait_st = 0; gnt_delay = 6;
    @(negedge clk);
    ctl_write = 1'b1; cfg_addr = 32'h0; cfg_count = 8'd1; base = '0;
    acks = 0; done_cnt = 0; order_err = 0;
    ctl_start = 1'b1;
    repeat (3) @(negedge clk);
    chk(eng_state == 2'd1, "R8 waiting state", 32'(eng_state), 1);
    chk(bus_req && !bus_cyc, "R9 request without cycle", {bus_req, bus_cyc}, 32'b10);
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (done_cnt != 0) break;
    end
    chk(acks == 1, "R9 cycle after grant", 32'(acks), 1);
    release_start();
    gnt_delay = 0;
  endtask

  initial begin
    t_reset();
    t_write(5, 0);
    t_write(16, 3);
    t_read(7, 2);
    t_read(1, 0);
    t_zero();
    t_clamp();
    t_hold();
    t_late_grant();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule